// File: doc/BRIEF.md
# Dual-Channel Data-Ready Generator

This block turns the per-channel sample strobes of a two-channel converter into one active-low data-ready pin and a two-bit active-low status field. The two channels decimate at the same rate, but one channel's strobe can be offset from the other's by a signed phase delay. The strobe can come earlier or later, or both strobes can land in the same cycle. The block runs on the modulator clock, so one clock cycle is one modulator clock period.

A two-bit mode input chooses when the pin pulses. In linked mode the pulse waits for the lagging channel, and both status bits change together. The other modes follow channel 0 alone, follow channel 1 alone, or pulse on new data from either channel. A channel that is shut down or held in reset is treated as asleep and is left out of the decision. A linked pair with one sleeping channel therefore still pulses for the channel that is awake.

The pin drives a low pulse while active. When idle it is either driven high or released to high impedance, as a control bit selects. The status bit of a channel goes back to not-ready when that channel's data is read.

Top module: `drg_top`

## Requirements
- R1: Each pulse on the data-ready pin lasts exactly one clock cycle. It appears in the cycle after the strobe that triggers it. Strobes arriving every OSR cycles give one pulse every OSR cycles.
- R2: In linked mode (drMode = 2'b00) with both channels awake, there is no pulse on the leading channel's strobe. The pulse comes in the cycle after the lagging channel's strobe, and both status bits go to ready in that same cycle. This holds for either sign of the phase offset.
- R3: In linked mode, strobes from both channels in the same cycle give exactly one pulse, in the next cycle.
- R4: A channel is asleep while its shutdown or reset bit is 1. Its strobes are ignored and its status bit stays not-ready. In linked mode the pin then pulses on the strobe of the channel that is awake.
- R5: drMode = 2'b01 pulses only on channel 0 strobes, and drMode = 2'b10 pulses only on channel 1 strobes.
- R6: drMode = 2'b11 pulses in the cycle after a strobe from either awake channel.
- R7: In modes 2'b01, 2'b10 and 2'b11, each awake channel's status bit goes to ready in the cycle after its own strobe, whether or not the pin pulses.
- R8: statusN is active-low, with bit 0 for channel 0 and bit 1 for channel 1. A value of 2'b11 means neither channel is ready. A pulse on readCh[c] returns bit c to 1. A new strobe in the same cycle as a read wins, and the bit goes to ready.
- R9: While rstN is low the pin is inactive and statusN is 2'b11. Strobes applied during reset have no effect.
- R10: The pin is active-low, with drPinVal as its level and drPinEn as its output enable. During a pulse it is driven low. When idle it is driven high if drHizN = 1 and released (drPinEn = 0) if drHizN = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rstN | input | 1 | Asynchronous active-low reset; holds the pin inactive |
| chanValid | input | 2 | One-cycle new-sample strobes, bit c for channel c |
| chanShutdown | input | 2 | Per-channel shutdown |
| chanReset | input | 2 | Per-channel reset |
| drMode | input | 2 | 00 linked, 01 channel 0, 10 channel 1, 11 either |
| drHizN | input | 1 | 1: drive high when idle, 0: high impedance when idle |
| readCh | input | 2 | Per-channel data-read strobes |
| drPinVal | output | 1 | Data-ready pin level |
| drPinEn | output | 1 | Data-ready pin output enable |
| statusN | output | 2 | Active-low per-channel ready status |

## Verification
The hardest case to reach from the ports is a linked pair whose first strobe has been held internally, waiting for the second. No output shows that held state until the lagging strobe arrives. The bench separates the two strobes by a chosen gap, with each channel leading in turn, and checks the pin and status in every cycle between them. It then runs a periodic strobe pattern with the offset on each side and counts the pulses and their widths. For the sleeping-channel cases, a channel is put to sleep by shutdown and, separately, by reset. Its strobes keep arriving, and the bench checks that only the awake channel drives the pin.

// File: rtl/drg_pkg.sv
`timescale 1ns/1ps
package drg_pkg;
  localparam int DRG_NCH = 2;

  typedef enum logic [1:0] {
    DRM_LINKED = 2'b00,
    DRM_CH0    = 2'b01,
    DRM_CH1    = 2'b10,
    DRM_EITHER = 2'b11
  } drMode_e;

  // strobes from the control to the datapath, valid for one cycle
  typedef struct packed {
    logic               fire;
    logic [DRG_NCH-1:0] setReady;
    logic [DRG_NCH-1:0] setPend;
    logic [DRG_NCH-1:0] clrPend;
  } drStrobes_t;
endpackage

// File: rtl/drg_ctrl.sv
`timescale 1ns/1ps
module drg_ctrl
  import drg_pkg::*;
#(
  parameter int NCH = DRG_NCH
) (
  input  logic [NCH-1:0] chanValid,
  input  logic [NCH-1:0] chanShutdown,
  input  logic [NCH-1:0] chanReset,
  input  logic [NCH-1:0] pending,
  input  drMode_e        mode,
  output drStrobes_t     strb
);
  logic [NCH-1:0] awake;
  logic [NCH-1:0] fresh;
  logic [NCH-1:0] haveData;
  logic           pairDone;

  assign awake    = ~(chanShutdown | chanReset);
  assign fresh    = chanValid & awake;
  assign haveData = pending | fresh;
  // every awake channel holds data, and at least one channel is awake
  assign pairDone = (&(haveData | ~awake)) & (|awake);

  always_comb begin
    strb = '0;
    case (mode)
      DRM_LINKED: begin
        strb.fire     = pairDone;
        strb.setReady = pairDone ? awake : '0;
        strb.setPend  = fresh;
        strb.clrPend  = ~awake | (pairDone ? {NCH{1'b1}} : {NCH{1'b0}});
      end
      DRM_CH0: begin
        strb.fire     = fresh[0];
        strb.setReady = fresh;
        strb.clrPend  = '1;
      end
      DRM_CH1: begin
        strb.fire     = fresh[1];
        strb.setReady = fresh;
        strb.clrPend  = '1;
      end
      default: begin
        strb.fire     = |fresh;
        strb.setReady = fresh;
        strb.clrPend  = '1;
      end
    endcase
  end
endmodule

// File: rtl/drg_datapath.sv
`timescale 1ns/1ps
module drg_datapath
  import drg_pkg::*;
#(
  parameter int NCH = DRG_NCH
) (
  input  logic           clk,
  input  logic           rstN,
  input  drStrobes_t     strb,
  input  logic [NCH-1:0] readCh,
  input  logic           drHizN,
  output logic [NCH-1:0] pending,
  output logic [NCH-1:0] statusN,
  output logic           drPinVal,
  output logic           drPinEn
);
  logic drLow;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pending[c] <= 1'b0;
        statusN[c] <= 1'b1;
      end else begin
        if (strb.clrPend[c])      pending[c] <= 1'b0;
        else if (strb.setPend[c]) pending[c] <= 1'b1;

        if (strb.setReady[c])     statusN[c] <= 1'b0;
        else if (readCh[c])       statusN[c] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) drLow <= 1'b0;
    else       drLow <= strb.fire;
  end

  assign drPinVal = ~drLow;
  assign drPinEn  = drLow | drHizN;
endmodule

// File: rtl/drg_top.sv
`timescale 1ns/1ps
module drg_top
  import drg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] chanValid,
  input  logic [1:0] chanShutdown,
  input  logic [1:0] chanReset,
  input  logic [1:0] drMode,
  input  logic       drHizN,
  input  logic [1:0] readCh,
  output logic       drPinVal,
  output logic       drPinEn,
  output logic [1:0] statusN
);
  drStrobes_t   strb;
  logic [1:0]   pending;

  drg_ctrl #(.NCH(DRG_NCH)) u_ctrl (
    .chanValid    (chanValid),
    .chanShutdown (chanShutdown),
    .chanReset    (chanReset),
    .pending      (pending),
    .mode         (drMode_e'(drMode)),
    .strb         (strb)
  );

  drg_datapath #(.NCH(DRG_NCH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .readCh   (readCh),
    .drHizN   (drHizN),
    .pending  (pending),
    .statusN  (statusN),
    .drPinVal (drPinVal),
    .drPinEn  (drPinEn)
  );
endmodule

// File: rtl/drg_checker.sv
`timescale 1ns/1ps
module drg_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] chanValid,
  input logic [1:0] chanShutdown,
  input logic [1:0] chanReset,
  input logic [1:0] drMode,
  input logic       drHizN,
  input logic [1:0] readCh,
  input logic       drPinVal,
  input logic       drPinEn,
  input logic [1:0] statusN
);
  logic       drAct;
  logic [1:0] awakeP;
  assign drAct  = drPinEn & ~drPinVal;
  assign awakeP = ~(chanShutdown | chanReset);

  // R1: a pulse always follows an awake strobe in the previous cycle
  a_r1_pulse_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    drAct |-> $past(|(chanValid & awakeP)));

  // R2: in linked mode a status bit only becomes ready together with a pulse
  a_r2_linked_status_with_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (($past(drMode) == 2'b00) && (($past(statusN) & ~statusN) != 2'b00)) |-> drAct);

  // R4: a sleeping channel never turns ready
  a_r4_sleep_ch0: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!awakeP[0]) && $past(statusN[0])) |-> statusN[0]);
  a_r4_sleep_ch1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!awakeP[1]) && $past(statusN[1])) |-> statusN[1]);

  // R8: a read with no competing strobe clears the ready state (independent modes)
  a_r8_read_ch0: assert property (@(posedge clk) disable iff (!rstN)
    $past(readCh[0] && !chanValid[0] && drMode != 2'b00) |-> statusN[0]);

  // R10: idle pin level follows the high-impedance control
  a_r10_idle_pin: assert property (@(posedge clk) disable iff (!rstN)
    !drAct |-> ((drPinEn == drHizN) && (!drPinEn || drPinVal)));

  // R9: reset holds the pin inactive and status not-ready
  always @(negedge clk) begin
    if (!rstN) begin
      a_r9_reset_idle: assert (!drAct && statusN == 2'b11);
    end
  end
endmodule

bind drg_top drg_checker u_drg_checker (
  .clk          (clk),
  .rstN         (rstN),
  .chanValid    (chanValid),
  .chanShutdown (chanShutdown),
  .chanReset    (chanReset),
  .drMode       (drMode),
  .drHizN       (drHizN),
  .readCh       (readCh),
  .drPinVal     (drPinVal),
  .drPinEn      (drPinEn),
  .statusN      (statusN)
);

// File: tb/sim_drg_top.sv
`timescale 1ns/1ps
module sim_drg_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] chanValid = 2'b00;
  logic [1:0] chanShutdown = 2'b00;
  logic [1:0] chanReset = 2'b00;
  logic [1:0] drMode = 2'b00;
  logic       drHizN = 1'b1;
  logic [1:0] readCh = 2'b00;
  logic       drPinVal;
  logic       drPinEn;
  logic [1:0] statusN;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  drg_top u0 (
    .clk(clk), .rstN(rstN), .chanValid(chanValid), .chanShutdown(chanShutdown),
    .chanReset(chanReset), .drMode(drMode), .drHizN(drHizN), .readCh(readCh),
    .drPinVal(drPinVal), .drPinEn(drPinEn), .statusN(statusN)
  );

  function automatic int drAct();
    return (drPinEn && !drPinVal) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clearStatus();
    chanValid = 2'b00;
    readCh = 2'b11;
    tick();
    readCh = 2'b00;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    tick(); tick();
    chk("R9 pin idle in reset", drAct(), 0);
    chk("R9 status in reset", int'(statusN), 3);
    chk("R10 idle driven", int'(drPinEn), 1);
    chanValid = 2'b11;
    tick();
    chk("R9 strobe ignored in reset", drAct(), 0);
    chk("R9 status after strobe in reset", int'(statusN), 3);
    chanValid = 2'b00;
    tick();
    rstN = 1'b1;
    tick();
  endtask

  // lead: channel whose strobe comes first; gap: cycles between strobes
  task automatic t_linked(input int lead, input int gap);
    drMode = 2'b00;
    clearStatus();
    chanValid = 2'b00;
    chanValid[lead] = 1'b1;
    tick();
    chanValid = 2'b00;
    chk("R2 no pulse on leading strobe", drAct(), 0);
    chk("R2 status unchanged after leading strobe", int'(statusN), 3);
    for (int i = 1; i < gap; i++) begin
      tick();
      chk("R2 no pulse while waiting", drAct(), 0);
    end
    chanValid[1-lead] = 1'b1;
    tick();
    chanValid = 2'b00;
    chk("R2 pulse after lagging strobe", drAct(), 1);
    chk("R2 both status ready together", int'(statusN), 0);
    tick();
    chk("R1 pulse one cycle wide", drAct(), 0);
  endtask

  task automatic t_coincide();
    drMode = 2'b00;
    clearStatus();
    chanValid = 2'b11;
    tick();
    chanValid = 2'b00;
    chk("R3 pulse on coincident strobes", drAct(), 1);
    chk("R3 status both ready", int'(statusN), 0);
    tick();
    chk("R3 single pulse", drAct(), 0);
  endtask

  task automatic t_sleep();
    drMode = 2'b00;
    chanShutdown = 2'b10;
    clearStatus();
    chanValid = 2'b11;
    tick();
    chanValid = 2'b00;
    chk("R4 pulse for awake ch0 (ch1 shutdown)", drAct(), 1);
    chk("R4 status only ch0 ready", int'(statusN), 2);
    tick();
    chanShutdown = 2'b00;
    chanReset = 2'b01;
    clearStatus();
    chanValid = 2'b01;
    tick();
    chk("R4 strobe of channel in reset ignored", drAct(), 0);
    chanValid = 2'b10;
    tick();
    chanValid = 2'b00;
    chk("R4 pulse for awake ch1 (ch0 reset)", drAct(), 1);
    chk("R4 status only ch1 ready", int'(statusN), 1);
    tick();
    chanReset = 2'b00;
    tick();
  endtask

  task automatic t_single();
    drMode = 2'b01;
    clearStatus();
    chanValid = 2'b10;
    tick();
    chk("R5 mode 01 ignores ch1 for pin", drAct(), 0);
    chk("R7 ch1 status ready in mode 01", int'(statusN), 1);
    chanValid = 2'b01;
    tick();
    chanValid = 2'b00;
    chk("R5 mode 01 pulses on ch0", drAct(), 1);
    chk("R7 ch0 status ready", int'(statusN), 0);
    tick();
    drMode = 2'b10;
    clearStatus();
    chanValid = 2'b01;
    tick();
    chk("R5 mode 10 ignores ch0 for pin", drAct(), 0);
    chk("R7 ch0 status ready in mode 10", int'(statusN), 2);
    chanValid = 2'b10;
    tick();
    chanValid = 2'b00;
    chk("R5 mode 10 pulses on ch1", drAct(), 1);
    tick();
  endtask

  task automatic t_either();
    drMode = 2'b11;
    clearStatus();
    chanValid = 2'b01;
    tick();
    chanValid = 2'b00;
    chk("R6 pulse on ch0", drAct(), 1);
    tick();
    chk("R6 pulse ends", drAct(), 0);
    chanValid = 2'b10;
    tick();
    chanValid = 2'b00;
    chk("R6 pulse on ch1", drAct(), 1);
    chk("R7 both ready in mode 11", int'(statusN), 0);
    tick();
  endtask

  task automatic t_read();
    drMode = 2'b01;
    clearStatus();
    chanValid = 2'b01;
    tick();
    chanValid = 2'b00;
    chk("R8 ch0 ready after strobe", int'(statusN), 2);
    readCh = 2'b01;
    tick();
    readCh = 2'b00;
    chk("R8 read returns ch0 to not-ready", int'(statusN), 3);
    chanValid = 2'b01;
    readCh = 2'b01;
    tick();
    chanValid = 2'b00;
    readCh = 2'b00;
    chk("R8 new data wins over read", int'(statusN), 2);
    tick();
  endtask

  task automatic t_hiz();
    drHizN = 1'b0;
    drMode = 2'b11;
    tick();
    chk("R10 idle released", int'(drPinEn), 0);
    chanValid = 2'b01;
    tick();
    chanValid = 2'b00;
    chk("R10 pulse driven", int'(drPinEn), 1);
    chk("R10 pulse low", int'(drPinVal), 0);
    tick();
    chk("R10 released after pulse", int'(drPinEn), 0);
    drHizN = 1'b1;
    tick();
    chk("R10 idle driven high", int'(drPinEn && drPinVal), 1);
  endtask

  // periodic strobes with OSR 4; lead channel first, the other ph cycles later
  task automatic t_rate(input int lead, input int ph);
    int pulses = 0;
    int prev = 0;
    int wide = 0;
    drMode = 2'b00;
    clearStatus();
    for (int c = 0; c < 32; c++) begin
      chanValid = 2'b00;
      chanValid[lead]   = ((c % 4) == 0);
      chanValid[1-lead] = (((c + 4 - ph) % 4) == 0) && (c >= ph);
      tick();
      if (drAct() == 1) begin
        pulses++;
        if (prev == 1) wide++;
      end
      prev = drAct();
    end
    chanValid = 2'b00;
    tick();
    chk("R1 one pulse per output sample", pulses, 8);
    chk("R1 no pulse wider than a cycle", wide, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_linked(0, 3);
    t_linked(1, 2);
    t_linked(0, 1);
    t_coincide();
    t_sleep();
    t_single();
    t_either();
    t_read();
    t_hiz();
    t_rate(0, 1);
    t_rate(1, 3);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule